// File: doc/BRIEF.md
# Counter-DAC Threshold Capture

This block turns an analog trip level into a held digital code. After the power-up sequencer has qualified the supply and the enable, it sends a start strobe. The block then walks an up-counter from zero, one step per prescaled tick. The counter value goes out as the code for an external DAC. An external comparator reports whether the DAC output has reached the sensed voltage, and the block samples that input once per step. When the comparator trips, the count freezes and a done flag rises. The done flag releases the soft-start phase.

The frozen code is a register value, so it does not droop. It stays valid for as long as the supply-good flag stays high. A low level on the input with the highest setting takes no steps at all. A level at full scale takes the maximum capture time, which is `(2**CODE_W) * TICK_DIV` clock cycles. If the comparator never trips, the counter stops at full scale and still reports done. Loss of supply-good clears everything. A new start strobe is then needed for a fresh capture.

Top module: `ramp_capture`

## Requirements
- R1: After synchronous reset, `code_o` is 0 and `done_o` is 0.
- R2: A start strobe seen while `supply_ok_i` is high begins a capture from code 0, and the code then rises by exactly one every `TICK_DIV` cycles. The code is 1 when `TICK_DIV` cycles have passed after the clock edge that takes in the strobe.
- R3: The comparator input goes through a two-flop synchronizer and is evaluated once per step. The capture ends at the first code N for which the comparator reads high, and N is then held on `code_o`.
- R4: `done_o` rises exactly `(N+1)*TICK_DIV` clock edges after the edge that takes in the start strobe, where N is the final code. A higher captured code therefore takes longer to capture.
- R5: If the comparator has not tripped by full scale (`2**CODE_W-1`), the code saturates at full scale and `done_o` is still asserted.
- R6: While `done_o` is high and `supply_ok_i` stays high, `code_o` does not change, and start strobes have no effect.
- R7: When `supply_ok_i` is low at a clock edge, `code_o` is 0 and `done_o` is 0 after that edge. This also aborts a capture in progress, and start strobes are ignored while supply is low.
- R8: After a clear caused by supply loss, a start strobe with supply good performs a complete new capture.
- R9: A start strobe that arrives while a capture is running neither restarts the capture nor changes its result or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe from the power-up sequencer |
| supply_ok_i | input | 1 | Supply-good flag; when low, clears the held code |
| cmp_raw_i | input | 1 | Asynchronous comparator: DAC output has reached the sensed level |
| code_o | output | CODE_W | Counter code that drives the DAC and holds the captured level |
| done_o | output | 1 | Capture complete; the code is frozen |

## Verification
Some properties are checked on every cycle. These are the clear within one edge of supply loss, the frozen code while done stays high, the code moving only by +1 or back to zero, done rising only out of an active capture, and the strict spacing of prescaler ticks. The cycle-exact completion time and the final code for a given trip level can only be shown by the bench scenarios. The same holds for saturation at full scale, for strobes ignored during a capture and while holding, and for recapture after a supply drop. For these, the bench drives a comparator model fed from the code output.

// File: rtl/rc_pkg.sv
// Package: shared types for the counter-DAC threshold capture block.
package rc_pkg;
    // Capture sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } rc_state_t;
endpackage

// File: rtl/rc_sync2.sv
// rc_sync2: two-flop synchronizer for one asynchronous level input.
// Assumes the input is a slow level, so that a latency of two cycles is acceptable.
module rc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic sync_q;

    // Shift the asynchronous level through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/rc_prescaler.sv
// rc_prescaler: produces a one-cycle tick every DIV cycles while run_i is high.
// Assumes DIV >= 2. The phase restarts at zero whenever run_i is low.
module rc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Advance the phase while running, wrap at LAST, and hold zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && (phase_q == LAST);

    // Ticks are spaced by at least two cycles (R2)
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rc_step_counter.sv
// rc_step_counter: DAC code counter with synchronous clear and single-step increment.
// Assumes the caller never increments at full scale; at_max_o reports full scale.
module rc_step_counter #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [CODE_W-1:0] code_o,
    output logic              at_max_o
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;

    // Clear has priority, then a single step up
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            code_q <= '0;
        end else if (inc_i) begin
            code_q <= code_q + 1'b1;
        end
    end

    assign code_o   = code_q;
    assign at_max_o = (code_q == FULL);

    // The code only steps by one or returns to zero, and never wraps (R2, R5)
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1) || (code_q == '0));
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == FULL) |-> (code_q == FULL || code_q == '0));
endmodule

// File: rtl/ramp_capture.sv
// ramp_capture: steps a DAC code upward until the synchronized comparator trips,
// then freezes the code and raises done. Supply loss clears the code and done.
// Assumes TICK_DIV >= 3, so that a code change reaches the synchronizer output
// before the next step is evaluated.
module ramp_capture #(
    parameter int CODE_W   = 6,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              supply_ok_i,
    input  logic              cmp_raw_i,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);
    import rc_pkg::*;

    rc_state_t state_q;
    logic      cmp_s;
    logic      tick;
    logic      at_max;
    logic      cnt_clr;
    logic      cnt_inc;
    logic      running;

    rc_sync2 i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw_i),
        .sync_o  (cmp_s)
    );

    rc_prescaler #(.DIV(TICK_DIV)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .tick_o (tick)
    );

    rc_step_counter #(.CODE_W(CODE_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .inc_i    (cnt_inc),
        .code_o   (code_o),
        .at_max_o (at_max)
    );

    // Capture sequencer: idle -> run on start, run -> hold on trip or full scale
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_RUN;
                ST_RUN:  if (tick && (cmp_s || at_max)) state_q <= ST_HOLD;
                ST_HOLD: state_q <= ST_HOLD;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Counter control: clear when idle or unpowered, step on a tick with no trip
    always_comb begin
        running = (state_q == ST_RUN);
        cnt_clr = !supply_ok_i || (state_q == ST_IDLE);
        cnt_inc = running && tick && !cmp_s && !at_max;
    end

    assign done_o = (state_q == ST_HOLD);

    // Supply loss clears code and done at the next edge (R7)
    assert_supply_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (code_o == '0 && !done_o));
    // A held code stays frozen while done remains high (R6)
    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> $stable(code_o));
    // Done rises only out of an active capture (R3)
    assert_done_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(state_q) == ST_RUN));
    // The count moves only while a capture runs (R6)
    assert_count_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o) && code_o != '0) |-> ($past(state_q) == ST_RUN));
endmodule

// File: tb/test_ramp_capture.sv
// Bench for ramp_capture: an analog comparator model fed from code_o,
// random trip levels with a fixed seed, and directed corner cases.
module test_ramp_capture;
    localparam int CODE_W = 6;
    localparam int TD     = 4;
    localparam int FULL   = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              supply_ok_i = 1'b0;
    logic              cmp_raw_i;
    logic [CODE_W-1:0] code_o;
    logic              done_o;
    int                thr = 0;
    int                n_checks = 0;
    int                n_fails = 0;
    bit                finished = 1'b0;

    always #10 clk = ~clk;

    // Analog model: the comparator trips once the DAC code reaches the level
    always_comb cmp_raw_i = (int'(code_o) >= thr);

    ramp_capture #(.CODE_W(CODE_W), .TICK_DIV(TD)) i_ramp_capture (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .supply_ok_i(supply_ok_i),
        .cmp_raw_i(cmp_raw_i), .code_o(code_o), .done_o(done_o)
    );

    function automatic int exp_code(int level);
        return (level > FULL) ? FULL : level;
    endfunction

    function automatic int exp_cycles(int level);
        return (exp_code(level) + 1) * TD;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a capture at level lvl. When mid_start is set, strobe start again mid-run (R9)
    task automatic capture(int lvl, bit mid_start);
        int n = 0;
        @(negedge clk);
        thr = lvl;
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        while (!done_o && n < (FULL + 3) * TD) begin
            @(posedge clk);
            #1 n++;
            if (n == TD && lvl >= 1)
                check("R2 first step", int'(code_o), 1);
            if (mid_start && n == 2 * TD + 1) start_i = 1'b1;
            if (mid_start && n == 2 * TD + 2) start_i = 1'b0;
        end
        check(mid_start ? "R9 code" : "R3 code", int'(code_o), exp_code(lvl));
        check(lvl > FULL ? "R5 cycles" : "R4 cycles", n, exp_cycles(lvl));
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        thr = 1000;
        repeat (3) @(posedge clk);
        #1;
        check("R1 code", int'(code_o), 0);
        check("R1 done", int'(done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        supply_ok_i = 1'b1;
        repeat (3) @(negedge clk);

        // Directed cases: zero level, small, exact full scale, beyond full scale
        capture(0, 1'b0);
        @(negedge clk) supply_ok_i = 1'b0;
        @(negedge clk) supply_ok_i = 1'b1;
        capture(5, 1'b0);

        // R6: hold stays frozen and start is ignored
        repeat (50) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (3 * TD) @(negedge clk);
        check("R6 held code", int'(code_o), 5);
        check("R6 done", int'(done_o), 1);

        // R7: supply drop clears within one edge
        @(negedge clk) supply_ok_i = 1'b0;
        @(posedge clk);
        #1 check("R7 clear code", int'(code_o), 0);
        check("R7 clear done", int'(done_o), 0);
        start_i = 1'b1;
        repeat (4 * TD) @(negedge clk);
        start_i = 1'b0;
        check("R7 start ignored", int'(done_o) + int'(code_o), 0);
        supply_ok_i = 1'b1;
        repeat (2) @(negedge clk);

        capture(FULL, 1'b0);
        @(negedge clk) supply_ok_i = 1'b0;
        @(negedge clk) supply_ok_i = 1'b1;
        capture(FULL + 7, 1'b0);

        // R7: abort mid-run, then R8 recapture
        @(negedge clk) supply_ok_i = 1'b0;
        @(negedge clk) supply_ok_i = 1'b1;
        thr = 40;
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (10 * TD) @(negedge clk);
        supply_ok_i = 1'b0;
        @(negedge clk);
        check("R7 abort code", int'(code_o), 0);
        check("R7 abort done", int'(done_o), 0);
        supply_ok_i = 1'b1;
        @(negedge clk);
        capture(17, 1'b0);
        check("R8 recapture done", int'(done_o), 1);

        // R9: start strobe during a run
        @(negedge clk) supply_ok_i = 1'b0;
        @(negedge clk) supply_ok_i = 1'b1;
        capture(12, 1'b1);

        // Random levels
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) supply_ok_i = 1'b0;
            @(negedge clk) supply_ok_i = 1'b1;
            capture(int'($urandom_range(0, FULL + 4)), 1'b0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule